// File: doc/BRIEF.md
# Odd-Harmonic Sine-Term Analyzer

This block sits in the digital inner loop of a boost-type power-factor stage. It takes a frame of signed current-sense samples that spans one rectified half-line period. For each odd overtone of the line frequency (order 3, 5, 7 and up) it works out one coefficient: the samples are correlated against a built-in sine table. The fundamental, the even orders and all cosine terms are never computed. At the end of the frame each coefficient is scaled by a shared gain and saturated. The results are then published together with a one-cycle strobe. A later stage turns them back into a duty-factor correction.

Samples arrive slowly, one every several hundred microseconds, while the clock runs in the megahertz range. The block therefore uses one multiplier and walks through the overtones one cycle each after every sample. The gain ramps up from zero at one fixed step per completed frame, which gives a soft start. It falls back to zero whenever the enable input is low. A selection input passes either every overtone or only one of them.

Top module: `odd_harmonic_analyzer`

## Requirements
- R1: The sine table holds S[i] = round((2^(ROM_W-1)-1)·sin(2πi/FRAME_LEN)), which is 511 for ROM_W = 10. Sample k of a frame is the k-th accepted sample, k = 0 to FRAME_LEN-1. When a frame completes, channel j holds the coefficient C_j = Σ_k x[k]·S[(N_j·k) mod FRAME_LEN].
- R2: Channel j carries overtone order N_j = 2j+3. The channel occupies bits [j·OUT_W +: OUT_W] of amp_o. No channel carries the fundamental, an even order or a cosine term, so a pure fundamental input yields only the residue given by R1.
- R3: A published amplitude equals floor(C_j·g / 2^OUT_SHIFT) as a signed two's-complement value, where g is the gain applied to that frame.
- R4: A scaled value above 2^(OUT_W-1)-1 is clamped to that value. A scaled value below -2^(OUT_W-1) is clamped to that value.
- R5: amp_o and done_o update on the same clock edge, NUM_OVT+1 cycles after the edge that accepts the frame's last sample. done_o is high for exactly one cycle. amp_o holds its value between strobes.
- R6: Selection is sampled on the publishing edge. With sel_all_i = 1 every channel is published. With sel_all_i = 0 only channel sel_idx_i is published and every other channel reads 0. An index of NUM_OVT or more zeroes every channel.
- R7: On each publishing edge with enable_i high, the gain becomes min(g_prev + GAIN_STEP, gain_tgt_i), and that new value scales the frame. The gain changes on no other edge except as given in R8.
- R8: On every edge with enable_i low, the gain is cleared to 0. A frame that completes with enable_i low publishes all zeros. The ramp restarts from 0 once enable_i returns.
- R9: A sample accepted with smp_first_i = 1 becomes sample 0. All partial sums and sample positions of the interrupted frame are discarded.
- R10: A sample is accepted only when the block is idle. smp_valid_i is ignored for NUM_OVT cycles after an accepted sample, and for NUM_OVT+1 cycles after a frame's last sample.
- R11: After reset, amp_o is 0, done_o is 0 and the gain is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_first_i | input | 1 | Marks the strobed sample as frame position 0 |
| smp_i | input | SAMPLE_W | Signed current-sense sample |
| enable_i | input | 1 | Soft-start enable; low clears the gain |
| gain_tgt_i | input | GAIN_W | Final gain value, unsigned |
| sel_all_i | input | 1 | Publish every overtone |
| sel_idx_i | input | SEL_W | Overtone channel published when sel_all_i is low |
| amp_o | output | NUM_OVT·OUT_W | Scaled overtone amplitudes, channel j at bits [j·OUT_W +: OUT_W] |
| done_o | output | 1 | One-cycle frame-complete strobe |

## Verification
The bench builds the block with FRAME_LEN 32 and NUM_OVT 7. Overtone orders 3 to 15 therefore wrap the sine-table phase several times within a frame. With this width the selection index has one unused code, 7, which exercises the out-of-range case. GAIN_STEP is raised to 64, so the ramp reaches a target of 255 and clamps there within four frames. This leaves room for full-scale frames that drive the saturation limits in both directions, and for runs where the enable input drops or the target moves.

// File: rtl/ohsa_pkg.sv
package ohsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_FIN  = 2'd2
  } ohsa_st_e;

  // channel j analyses overtone 2j+3
  function automatic int ovt_order(input int ch);
    return 2 * ch + 3;
  endfunction
endpackage

// File: rtl/ohsa_sine_rom.sv
module ohsa_sine_rom #(
  parameter  int LEN   = 32,
  parameter  int ROM_W = 10,
  localparam int AW    = $clog2(LEN)
) (
  input  logic        [AW-1:0]    addr_i,
  output logic signed [ROM_W-1:0] data_o
);
  localparam real TWO_PI = 6.283185307179586;
  localparam int  PEAK   = 2 ** (ROM_W - 1) - 1;

  logic signed [ROM_W-1:0] tab [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_tab
    localparam int VAL = $rtoi($floor(real'(PEAK) * $sin(TWO_PI * real'(i) / real'(LEN)) + 0.5));
    assign tab[i] = ROM_W'(VAL);
  end

  assign data_o = (int'(addr_i) < LEN) ? tab[addr_i] : '0;
endmodule

// File: rtl/ohsa_mac_bank.sv
module ohsa_mac_bank
  import ohsa_pkg::*;
#(
  parameter  int LEN      = 32,
  parameter  int NUM_OVT  = 7,
  parameter  int SAMPLE_W = 12,
  parameter  int ROM_W    = 10,
  localparam int AW       = $clog2(LEN),
  localparam int SW       = (NUM_OVT > 1) ? $clog2(NUM_OVT) : 1,
  localparam int ACC_W    = SAMPLE_W + ROM_W + AW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       step_en_i,
  input  logic [SW-1:0]              step_i,
  input  logic                       restart_i,
  input  logic                       clr_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  output logic [NUM_OVT*ACC_W-1:0]   acc_o
);
  localparam int PW = SAMPLE_W + ROM_W;

  logic [AW:0]              ph_all [NUM_OVT];
  logic [AW-1:0]            ph_sel;
  logic [AW-1:0]            rom_addr;
  logic signed [ROM_W-1:0]  rom_val;
  logic signed [PW-1:0]     prod;
  logic signed [ACC_W-1:0]  prod_x;

  always_comb begin
    ph_sel = '0;
    for (int j = 0; j < NUM_OVT; j++) begin
      if (int'(step_i) == j) ph_sel = ph_all[j][AW-1:0];
    end
  end

  // sample 0 always hits sin(0)
  assign rom_addr = restart_i ? '0 : ph_sel;

  ohsa_sine_rom #(
    .LEN  (LEN),
    .ROM_W(ROM_W)
  ) u_rom (
    .addr_i(rom_addr),
    .data_o(rom_val)
  );

  assign prod   = smp_i * rom_val;
  assign prod_x = ACC_W'(prod);

  for (genvar j = 0; j < NUM_OVT; j++) begin : g_ch
    localparam int N = ovt_order(j);

    logic signed [ACC_W-1:0] acc_q;
    logic [AW:0]             ph_q;
    logic [AW:0]             ph_base;
    logic [AW:0]             ph_sum;
    logic                    hit;

    assign hit     = step_en_i && (int'(step_i) == j);
    assign ph_base = restart_i ? '0 : ph_q;
    assign ph_sum  = ph_base + (AW + 1)'(N % LEN);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= '0;
        ph_q  <= '0;
      end else if (clr_i) begin
        acc_q <= '0;
        ph_q  <= '0;
      end else if (hit) begin
        acc_q <= (restart_i ? '0 : acc_q) + prod_x;
        ph_q  <= (int'(ph_sum) >= LEN) ? ph_sum - (AW + 1)'(LEN) : ph_sum;
      end
    end

    assign ph_all[j]                 = ph_q;
    assign acc_o[j*ACC_W +: ACC_W]   = acc_q;
  end
endmodule

// File: rtl/ohsa_gain_ramp.sv
module ohsa_gain_ramp #(
  parameter int GAIN_W    = 8,
  parameter int GAIN_STEP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              adv_i,
  input  logic [GAIN_W-1:0] tgt_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [GAIN_W-1:0] gain_eff_o
);
  logic [GAIN_W:0]   sum;
  logic [GAIN_W-1:0] nxt;

  assign sum        = {1'b0, gain_o} + (GAIN_W + 1)'(GAIN_STEP);
  assign nxt        = (sum > {1'b0, tgt_i}) ? tgt_i : sum[GAIN_W-1:0];
  assign gain_eff_o = enable_i ? nxt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gain_o <= '0;
    else if (!enable_i) gain_o <= '0;
    else if (adv_i)     gain_o <= nxt;
  end
endmodule

// File: rtl/ohsa_out_stage.sv
module ohsa_out_stage #(
  parameter int NUM_OVT = 7,
  parameter int ACC_W   = 27,
  parameter int GAIN_W  = 8,
  parameter int OUT_W   = 16,
  parameter int SHIFT   = 14,
  parameter int SEL_W   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic                     sel_all_i,
  input  logic [SEL_W-1:0]         sel_idx_i,
  input  logic [NUM_OVT*ACC_W-1:0] acc_i,
  output logic [NUM_OVT*OUT_W-1:0] amp_o,
  output logic                     done_o
);
  localparam int     PW   = ACC_W + GAIN_W + 1;
  localparam longint HI_L = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam logic signed [PW-1:0] HI = PW'(HI_L);
  localparam logic signed [PW-1:0] LO = PW'(-HI_L - 1);

  for (genvar j = 0; j < NUM_OVT; j++) begin : g_ch
    logic signed [PW-1:0]    p;
    logic signed [PW-1:0]    sh;
    logic        [OUT_W-1:0] sat;
    logic        [OUT_W-1:0] amp_q;
    logic                    keep;

    assign p    = PW'($signed(acc_i[j*ACC_W +: ACC_W])) * $signed({{(PW - GAIN_W){1'b0}}, gain_i});
    assign sh   = p >>> SHIFT;
    assign sat  = (sh > HI) ? HI[OUT_W-1:0] : (sh < LO) ? LO[OUT_W-1:0] : sh[OUT_W-1:0];
    assign keep = sel_all_i || (int'(sel_idx_i) == j);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    amp_q <= '0;
      else if (cap_i) amp_q <= keep ? sat : '0;
    end

    assign amp_o[j*OUT_W +: OUT_W] = amp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= cap_i;
  end
endmodule

// File: rtl/odd_harmonic_analyzer.sv
module odd_harmonic_analyzer
  import ohsa_pkg::*;
#(
  parameter  int FRAME_LEN = 32,
  parameter  int NUM_OVT   = 7,
  parameter  int SAMPLE_W  = 12,
  parameter  int ROM_W     = 10,
  parameter  int GAIN_W    = 8,
  parameter  int GAIN_STEP = 16,
  parameter  int OUT_W     = 16,
  parameter  int OUT_SHIFT = 14,
  localparam int SEL_W     = $clog2(NUM_OVT + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       smp_valid_i,
  input  logic                       smp_first_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       enable_i,
  input  logic [GAIN_W-1:0]          gain_tgt_i,
  input  logic                       sel_all_i,
  input  logic [SEL_W-1:0]           sel_idx_i,
  output logic [NUM_OVT*OUT_W-1:0]   amp_o,
  output logic                       done_o
);
  localparam int AW    = $clog2(FRAME_LEN);
  localparam int SW    = (NUM_OVT > 1) ? $clog2(NUM_OVT) : 1;
  localparam int ACC_W = SAMPLE_W + ROM_W + AW;

  ohsa_st_e                  st_q;
  logic [SW-1:0]             step_q;
  logic [AW-1:0]             cnt_q;
  logic [AW-1:0]             idx_now;
  logic signed [SAMPLE_W-1:0] smp_q;
  logic                      restart_q;
  logic                      last_q;
  logic                      last_now;
  logic                      step_last;
  logic                      fin;
  logic [GAIN_W-1:0]         gain_cur;
  logic [GAIN_W-1:0]         gain_eff;
  logic [NUM_OVT*ACC_W-1:0]  acc_flat;

  assign idx_now   = smp_first_i ? '0 : cnt_q;
  assign last_now  = (int'(idx_now) == FRAME_LEN - 1);
  assign step_last = (int'(step_q) == NUM_OVT - 1);
  assign fin       = (st_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      step_q    <= '0;
      cnt_q     <= '0;
      smp_q     <= '0;
      restart_q <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (smp_valid_i) begin
            smp_q     <= smp_i;
            restart_q <= smp_first_i;
            last_q    <= last_now;
            cnt_q     <= last_now ? '0 : idx_now + AW'(1);
            step_q    <= '0;
            st_q      <= ST_MAC;
          end
        end
        ST_MAC: begin
          step_q <= step_q + SW'(1);
          if (step_last) st_q <= last_q ? ST_FIN : ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  ohsa_mac_bank #(
    .LEN     (FRAME_LEN),
    .NUM_OVT (NUM_OVT),
    .SAMPLE_W(SAMPLE_W),
    .ROM_W   (ROM_W)
  ) u_mac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_en_i(st_q == ST_MAC),
    .step_i   (step_q),
    .restart_i(restart_q),
    .clr_i    (fin),
    .smp_i    (smp_q),
    .acc_o    (acc_flat)
  );

  ohsa_gain_ramp #(
    .GAIN_W   (GAIN_W),
    .GAIN_STEP(GAIN_STEP)
  ) u_gain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .adv_i     (fin),
    .tgt_i     (gain_tgt_i),
    .gain_o    (gain_cur),
    .gain_eff_o(gain_eff)
  );

  ohsa_out_stage #(
    .NUM_OVT(NUM_OVT),
    .ACC_W  (ACC_W),
    .GAIN_W (GAIN_W),
    .OUT_W  (OUT_W),
    .SHIFT  (OUT_SHIFT),
    .SEL_W  (SEL_W)
  ) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (fin),
    .gain_i   (gain_eff),
    .sel_all_i(sel_all_i),
    .sel_idx_i(sel_idx_i),
    .acc_i    (acc_flat),
    .amp_o    (amp_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/odd_harmonic_analyzer_chk.sv
module odd_harmonic_analyzer_chk #(
  parameter int NUM_OVT   = 7,
  parameter int OUT_W     = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_STEP = 16,
  parameter int SEL_W     = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     enable_i,
  input logic                     sel_all_i,
  input logic [SEL_W-1:0]         sel_idx_i,
  input logic [NUM_OVT*OUT_W-1:0] amp_o,
  input logic                     done_o,
  input logic [GAIN_W-1:0]        gain_cur,
  input logic                     fin
);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_amp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(amp_o));

  a_r8_gain_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (gain_cur == '0));

  a_r7_gain_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && fin) |=> (int'(gain_cur) <= int'($past(gain_cur)) + GAIN_STEP));

  a_r7_gain_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_cur) |-> ($past(fin) || !$past(enable_i)));

  for (genvar j = 0; j < NUM_OVT; j++) begin : g_mask
    a_r6_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ($past(sel_all_i) || (int'($past(sel_idx_i)) == j)
                  || (amp_o[j*OUT_W +: OUT_W] == '0)));
  end
endmodule

bind odd_harmonic_analyzer odd_harmonic_analyzer_chk #(
  .NUM_OVT  (NUM_OVT),
  .OUT_W    (OUT_W),
  .GAIN_W   (GAIN_W),
  .GAIN_STEP(GAIN_STEP),
  .SEL_W    (SEL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .sel_all_i(sel_all_i),
  .sel_idx_i(sel_idx_i),
  .amp_o    (amp_o),
  .done_o   (done_o),
  .gain_cur (gain_cur),
  .fin      (fin)
);

// File: tb/odd_harmonic_analyzer_bench.sv
module odd_harmonic_analyzer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L     = 32;
  localparam int NOVT  = 7;
  localparam int SMPW  = 12;
  localparam int GW    = 8;
  localparam int STEP  = 64;
  localparam int OW    = 16;
  localparam int SH    = 14;
  localparam int SELW  = 3;
  localparam real TWO_PI = 6.283185307179586;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_first = 1'b0;
  logic signed [SMPW-1:0] smp = '0;
  logic enable = 1'b0;
  logic [GW-1:0] tgt = 8'd255;
  logic sel_all = 1'b1;
  logic [SELW-1:0] sel_idx = '0;
  logic [NOVT*OW-1:0] amp;
  logic done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R11";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  odd_harmonic_analyzer #(
    .FRAME_LEN(L), .NUM_OVT(NOVT), .SAMPLE_W(SMPW), .ROM_W(10),
    .GAIN_W(GW), .GAIN_STEP(STEP), .OUT_W(OW), .OUT_SHIFT(SH)
  ) u_odd_harmonic_analyzer (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid), .smp_first_i(smp_first),
    .smp_i(smp), .enable_i(enable), .gain_tgt_i(tgt), .sel_all_i(sel_all),
    .sel_idx_i(sel_idx), .amp_o(amp), .done_o(done)
  );

  function automatic int sine_ref(input int i);
    return $rtoi($floor(511.0 * $sin(TWO_PI * real'(i) / real'(L)) + 0.5));
  endfunction

  function automatic int wave(input int k, input int a1, input int n1, input int a2, input int n2);
    real x;
    int v;
    x = real'(a1) * $sin(TWO_PI * real'(n1 * k) / real'(L))
      + real'(a2) * $sin(TWO_PI * real'(n2 * k) / real'(L));
    v = $rtoi($floor(x + 0.5));
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    return v;
  endfunction

  // behavioural reference model
  longint acc_m [NOVT];
  logic [OW-1:0] exp_amp [NOVT];
  bit exp_done;
  int rem, cnt_m, gm;
  bit fin_m;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (acc_m[j]) begin acc_m[j] = 0; exp_amp[j] = '0; end
      exp_done = 0; rem = 0; cnt_m = 0; gm = 0; fin_m = 0;
    end else begin
      exp_done = 0;
      if (rem == 0) begin
        if (smp_valid) begin
          int k;
          k = smp_first ? 0 : cnt_m;
          if (smp_first) foreach (acc_m[j]) acc_m[j] = 0;
          foreach (acc_m[j]) acc_m[j] += longint'(smp) * sine_ref(((2*j+3) * k) % L);
          if (k == L-1) begin fin_m = 1; rem = NOVT + 1; cnt_m = 0; end
          else begin rem = NOVT; cnt_m = k + 1; end
        end
        if (!enable) gm = 0;
      end else begin
        rem--;
        if (rem == 0 && fin_m) begin
          int g;
          g = enable ? ((gm + STEP > int'(tgt)) ? int'(tgt) : gm + STEP) : 0;
          foreach (acc_m[j]) begin
            longint p, s, lim;
            lim = longint'(1) <<< (OW-1);
            p = acc_m[j] * g;
            s = p >>> SH;
            if (s > lim - 1) s = lim - 1;
            if (s < -lim) s = -lim;
            exp_amp[j] = (sel_all || int'(sel_idx) == j) ? OW'(s) : '0;
            acc_m[j] = 0;
          end
          gm = g;
          fin_m = 0;
          exp_done = 1;
        end else if (!enable) gm = 0;
      end
    end
  end

  task automatic chk(input string req, input bit ok, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int j = 0; j < NOVT; j++)
        chk({cur_req, " amp"}, amp[j*OW +: OW] == exp_amp[j], amp[j*OW +: OW], exp_amp[j]);
      chk({cur_req, " done"}, done == exp_done, done, exp_done);
    end
  end

  task automatic send(input int v, input bit first, input int gap);
    @(negedge clk_i);
    smp_valid = 1'b1; smp_first = first; smp = SMPW'(v);
    @(negedge clk_i);
    smp_valid = 1'b0; smp_first = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic frame(input int a1, input int n1, input int a2, input int n2, input bit use_first);
    for (int k = 0; k < L; k++) send(wave(k, a1, n1, a2, n2), use_first && k == 0, NOVT + 2);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 amp in reset", amp == '0, amp[OW-1:0], 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 amp after reset", amp == '0, amp[OW-1:0], 0);
    chk("R11 done after reset", done == 1'b0, done, 0);

    cur_req = "R1/R2/R3/R5/R7 ramp";
    enable = 1'b1;
    frame(1500, 3, 0, 0, 1);
    frame(1500, 3, 0, 0, 0);
    frame(900, 5, 700, 9, 1);
    cur_req = "R2 fundamental";
    frame(1800, 1, 0, 0, 1);

    cur_req = "R4 saturation";
    frame(2047, 3, 0, 0, 1);
    chk("R4 positive clamp", amp[0 +: OW] == 16'h7fff, amp[0 +: OW], 16'h7fff);
    frame(-2048, 3, 0, 0, 1);
    chk("R4 negative clamp", amp[0 +: OW] == 16'h8000, amp[0 +: OW], 16'h8000);

    cur_req = "R6 select";
    sel_all = 1'b0; sel_idx = 3'd1;
    frame(800, 5, 800, 7, 1);
    sel_idx = 3'd6;
    frame(800, 15, 600, 3, 1);
    sel_idx = 3'd7;
    frame(1000, 3, 900, 5, 1);
    chk("R6 out-of-range index", amp == '0, amp[OW-1:0], 0);
    sel_all = 1'b1;

    cur_req = "R8 enable";
    for (int k = 0; k < L; k++) begin
      if (k == 10) enable = 1'b0;
      if (k == 13) enable = 1'b1;
      send(wave(k, 1200, 3, 0, 0), k == 0, NOVT + 2);
    end
    enable = 1'b0;
    frame(1200, 3, 0, 0, 1);
    chk("R8 disabled frame zero", amp == '0, amp[OW-1:0], 0);
    enable = 1'b1;
    frame(1200, 3, 0, 0, 1);

    cur_req = "R9 restart";
    for (int k = 0; k < 10; k++) send(wave(k, 1000, 7, 0, 0), k == 0, NOVT + 2);
    frame(1200, 3, 500, 11, 1);
    for (int k = 0; k < 5; k++) send(wave(k, 1500, 5, 0, 0), 1'b0, NOVT + 2);
    frame(700, 9, 400, 13, 1);

    cur_req = "R10 busy";
    for (int k = 0; k < L; k++) begin
      @(negedge clk_i);
      smp_valid = 1'b1; smp_first = (k == 0); smp = SMPW'(wave(k, 1100, 5, 0, 0));
      @(negedge clk_i);
      smp_valid = 1'b0; smp_first = 1'b0;
      @(negedge clk_i);
      smp_valid = 1'b1; smp_first = 1'b1; smp = 12'sd2000;
      @(negedge clk_i);
      smp_valid = 1'b0; smp_first = 1'b0;
      repeat (NOVT + 1) @(negedge clk_i);
    end
    repeat (3) @(negedge clk_i);

    cur_req = "R7 target";
    tgt = 8'd100;
    frame(1500, 3, 800, 7, 1);
    tgt = 8'd255;
    frame(1500, 3, 800, 7, 1);

    repeat (5) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog %s act=%0d exp=%0d", cur_req, cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule